// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the command pins of a single-rank SDRAM bus with four banks and never drives the bus. On every rising clock edge it turns chip select, row strobe, column strobe, write enable, the two bank bits and the auto-precharge address bit into one command. It keeps, for each bank, whether a row is open, how many clocks have passed since that bank was last activated and since it was last closed. It also tracks the current burst and whether that burst ends in an automatic precharge.

When a command breaks a sequencing rule or a minimum spacing, the monitor raises an error flag and records a code that names the rule. Both stay set until reset, and only the first violation is recorded. A separate window counter counts refresh commands. If fewer than a set number arrive within one window, it flags a refresh shortfall. The refresh count of the current window is visible at a port. All spacings are given in clocks as parameters.

Command encoding when chip select is low, as {row strobe, column strobe, write enable}: 000 mode-register set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is taken only when `cs_n` is low. With `cs_n` high, the other pins have no effect on bank state or errors. After reset, `err_flag` is 0, `err_code` is 0 and `refresh_count` is 0.
- R2: A mode-register set or a refresh issued while any bank is open sets error code 1.
- R3: Any command other than no-op on either of the two clocks after a mode-register set sets code 2. A command on the third clock is accepted.
- R4: A read or write with `a10` high starts a burst of `BURST_LEN` clocks that ends in an automatic precharge. A read or write to any bank on a clock inside that burst sets code 5. The bank closes on the last clock of the burst. A read or write to that bank afterwards sets code 3.
- R5: A precharge with `a10` high closes all four banks, whatever `ba` holds.
- R6: A burst stop ends the tracked burst. If the burst was auto-precharging, its bank closes at once. A following read or write is then judged as a read or write to a closed bank, not as one inside a burst.
- R7: A read or write to a bank with no open row sets code 3. An activate to a bank that is already open sets code 4.
- R8: A read or write fewer than `T_RCD` clocks after its bank was activated sets code 7.
- R9: An activate fewer than `T_RP` clocks after its bank was closed sets code 6. The bank may have been closed by a precharge or by the end of an auto-precharge burst. A precharge of an open bank fewer than `T_RAS` clocks after its activate sets code 8.
- R10: Two activates fewer than `T_RRD` clocks apart, to any banks, set code 9.
- R11: `refresh_count` counts refreshes in the current window of `REF_WINDOW` clocks. It returns to 0 when the window closes. A window closing with fewer than `REF_MIN` refreshes sets code 10.
- R12: Once set, `err_flag` stays high and `err_code` keeps the code of the first violation until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank select |
| a10 | input | 1 | Auto-precharge on read/write; all-bank select on precharge |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation (0 = none) |
| refresh_count | output | CNT_W | Refreshes seen in the current window |

## Verification
The bench runs legal and illegal variants of each sequence, with the second one clock earlier than the first. The contrast shows that each spacing limit sits exactly on its parameter and not one clock off. Command patterns sent with chip select high are followed by a read that would only be legal if they had been taken, which separates masking from decoding. Auto-precharge bursts are ended both naturally and by burst stop, and then hit with reads and activates. The resulting code tells whether the bank closed, when it closed, and whether the burst was still seen as running. Two refresh windows, one filled and one empty, check the counter, its clearing and the shortfall error.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_OPEN     = 4'd1,
    ERR_MRS_GAP  = 4'd2,
    ERR_CLOSED   = 4'd3,
    ERR_REOPEN   = 4'd4,
    ERR_AP_BUSY  = 4'd5,
    ERR_TRP      = 4'd6,
    ERR_TRCD     = 4'd7,
    ERR_TRAS     = 4'd8,
    ERR_TRRD     = 4'd9,
    ERR_REFRESH  = 4'd10
  } err_e;

  // Deselected cycles read as no-op.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_NOP;
    return cmd_e'({ras_n, cas_n, we_n});
  endfunction

  // True when fewer clocks than required have elapsed.
  function automatic logic gap_short(input int unsigned elapsed, input int unsigned need);
    return elapsed < need;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd,
  output logic is_rw,
  output logic rw_autopre
);
  always_comb begin
    cmd        = decode_cmd(cs_n, ras_n, cas_n, we_n);
    is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
    rw_autopre = is_rw && a10;
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int unsigned TMAX = 8,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_act,
  input  logic          do_close,
  output logic          is_open,
  output logic [TW-1:0] t_act,
  output logic [TW-1:0] t_pre
);
  localparam logic [TW-1:0] SAT = TW'(TMAX);

  // Timers read e-p at edge e when loaded with 1 at edge p.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      t_act   <= SAT;
      t_pre   <= SAT;
    end else begin
      if (t_act != SAT) t_act <= t_act + 1'b1;
      if (t_pre != SAT) t_pre <= t_pre + 1'b1;
      if (do_act) begin
        is_open <= 1'b1;
        t_act   <= TW'(1);
      end else if (do_close && is_open) begin
        is_open <= 1'b0;
        t_pre   <= TW'(1);
      end
    end
  end

  assert_act_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> is_open);
  assert_close_shuts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_close && !do_act) |=> !is_open);
endmodule

// File: rtl/sdram_refresh_window.sv
module sdram_refresh_window #(
  parameter int unsigned WINDOW  = 1000,
  parameter int unsigned MIN_REF = 4,
  parameter int unsigned CNT_W   = $clog2(WINDOW + 1),
  localparam int WW = $clog2(WINDOW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_seen,
  output logic [CNT_W-1:0] count,
  output logic             win_end,
  output logic             deficit
);
  logic [WW-1:0] win_cnt;

  always_comb begin
    win_end = (win_cnt == WW'(WINDOW - 1));
    deficit = win_end && ((32'(count) + 32'(ref_seen)) < MIN_REF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      count   <= '0;
    end else if (win_end) begin
      win_cnt <= '0;
      count   <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (ref_seen && (count != {CNT_W{1'b1}})) count <= count + 1'b1;
    end
  end

  assert_window_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (count == '0));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned BANK_BITS  = 2,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned T_RCD      = 3,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RAS      = 6,
  parameter int unsigned T_RRD      = 2,
  parameter int unsigned REF_WINDOW = 8_500_000,
  parameter int unsigned REF_MIN    = 4096,
  parameter int unsigned CNT_W      = $clog2(REF_WINDOW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  output logic                 err_flag,
  output logic [3:0]           err_code,
  output logic [CNT_W-1:0]     refresh_count
);
  localparam int unsigned NB    = 1 << BANK_BITS;
  localparam int unsigned TM01  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned TM23  = (T_RAS > T_RRD) ? T_RAS : T_RRD;
  localparam int unsigned TMAX  = (TM01 > TM23) ? TM01 : TM23;
  localparam int          TW    = $clog2(TMAX + 1);
  localparam int          BLW   = $clog2(BURST_LEN + 1);
  localparam logic        AP_NOW = (BURST_LEN == 1);

  // Named events for checks.
  cmd_e                 cmd;
  logic                 is_rw, rw_autopre;
  logic [NB-1:0]        bank_open, act_vec, close_vec, pre_target;
  logic [TW-1:0]        t_act [NB];
  logic [TW-1:0]        t_pre [NB];
  logic [TW-1:0]        t_rrd;
  logic [BLW-1:0]       burst_left;
  logic                 burst_ap;
  logic [BANK_BITS-1:0] burst_bank;
  logic [1:0]           mrs_gap;
  logic                 in_burst, ap_busy, burst_end_ap, bst_ap, tras_bad;
  logic                 ref_seen, win_end, deficit;
  err_e                 err_now;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .cmd(cmd), .is_rw(is_rw), .rw_autopre(rw_autopre)
  );

  always_comb begin
    in_burst     = (burst_left != '0);
    ap_busy      = in_burst && burst_ap;
    burst_end_ap = ap_busy && (burst_left == BLW'(1));
    bst_ap       = (cmd == CMD_BST) && ap_busy;
    ref_seen     = (cmd == CMD_REF);
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_comb begin
      act_vec[b]    = (cmd == CMD_ACT) && (ba == BANK_BITS'(b));
      pre_target[b] = (cmd == CMD_PRE) && (a10 || (ba == BANK_BITS'(b)));
      close_vec[b]  = pre_target[b]
                    || ((burst_end_ap || bst_ap) && (burst_bank == BANK_BITS'(b)))
                    || (AP_NOW && rw_autopre && !ap_busy && (ba == BANK_BITS'(b)));
    end
    sdram_bank_tracker #(.TMAX(TMAX)) u_bank (
      .clk(clk), .rst_n(rst_n), .do_act(act_vec[b]), .do_close(close_vec[b]),
      .is_open(bank_open[b]), .t_act(t_act[b]), .t_pre(t_pre[b])
    );
  end

  always_comb begin
    tras_bad = 1'b0;
    for (int b = 0; b < NB; b++)
      if (pre_target[b] && bank_open[b] && gap_short(32'(t_act[b]), T_RAS))
        tras_bad = 1'b1;
  end

  sdram_refresh_window #(.WINDOW(REF_WINDOW), .MIN_REF(REF_MIN), .CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_seen(ref_seen),
    .count(refresh_count), .win_end(win_end), .deficit(deficit)
  );

  // Rule priority: earlier lines win.
  always_comb begin
    err_now = ERR_NONE;
    if ((mrs_gap != 2'd0) && (cmd != CMD_NOP))                    err_now = ERR_MRS_GAP;
    else if (((cmd == CMD_MRS) || (cmd == CMD_REF)) && |bank_open) err_now = ERR_OPEN;
    else if (is_rw && ap_busy)                                     err_now = ERR_AP_BUSY;
    else if (is_rw && !bank_open[ba])                              err_now = ERR_CLOSED;
    else if (is_rw && gap_short(32'(t_act[ba]), T_RCD))            err_now = ERR_TRCD;
    else if ((cmd == CMD_ACT) && bank_open[ba])                    err_now = ERR_REOPEN;
    else if ((cmd == CMD_ACT) && gap_short(32'(t_pre[ba]), T_RP))  err_now = ERR_TRP;
    else if ((cmd == CMD_ACT) && gap_short(32'(t_rrd), T_RRD))     err_now = ERR_TRRD;
    else if (tras_bad)                                             err_now = ERR_TRAS;
    else if (deficit)                                              err_now = ERR_REFRESH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_left <= '0;
      burst_ap   <= 1'b0;
      burst_bank <= '0;
      mrs_gap    <= 2'd0;
      t_rrd      <= TW'(TMAX);
      err_flag   <= 1'b0;
      err_code   <= ERR_NONE;
    end else begin
      if (is_rw && !ap_busy) begin
        burst_left <= BLW'(BURST_LEN - 1);
        burst_ap   <= a10;
        burst_bank <= ba;
      end else if (cmd == CMD_BST) begin
        burst_left <= '0;
      end else if (in_burst) begin
        burst_left <= burst_left - 1'b1;
      end

      if (cmd == CMD_MRS)       mrs_gap <= 2'd2;
      else if (mrs_gap != 2'd0) mrs_gap <= mrs_gap - 1'b1;

      if (cmd == CMD_ACT)               t_rrd <= TW'(1);
      else if (t_rrd != TW'(TMAX))      t_rrd <= t_rrd + 1'b1;

      if (!err_flag && (err_now != ERR_NONE)) begin
        err_flag <= 1'b1;
        err_code <= err_now;
      end
    end
  end

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && $stable(err_code)));
  assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_PRE) && a10) |=> (bank_open == '0));
  assert_ap_end_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end_ap && (cmd != CMD_ACT)) |=> !bank_open[$past(burst_bank)]);
  assert_bst_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_BST) |=> (burst_left == '0));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_test;
  localparam int WIN = 4000;
  localparam int CW  = $clog2(WIN + 1);
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR = 3'b100, C_RD = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic err_flag;
  logic [3:0] err_code;
  logic [CW-1:0] refresh_count;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.BANK_BITS(2), .BURST_LEN(4), .T_RCD(3), .T_RP(3), .T_RAS(6),
                      .T_RRD(2), .REF_WINDOW(WIN), .REF_MIN(2), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .err_flag(err_flag), .err_code(err_code),
    .refresh_count(refresh_count));

  typedef struct {
    logic       flag;
    logic [3:0] code;
    logic       use_cnt;
    int         cnt;
    string      tag;
  } exp_t;
  exp_t sb[$];
  event chk_ev;
  int checks = 0, failures = 0;
  bit done = 0;

  // Monitor: pops expected items and compares.
  always begin
    @(chk_ev);
    #0.5;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (err_flag !== e.flag || err_code !== e.code) begin
        failures++;
        $display("FAIL %s: flag/code actual=%0b/%0d expected=%0b/%0d",
                 e.tag, err_flag, err_code, e.flag, e.code);
      end
      if (e.use_cnt && (int'(refresh_count) != e.cnt)) begin
        failures++;
        $display("FAIL %s: refresh_count actual=%0d expected=%0d",
                 e.tag, refresh_count, e.cnt);
      end
    end
  end

  task automatic drive(input logic cs, input logic [2:0] c, input logic [1:0] b, input logic ap);
    @(negedge clk);
    cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; a10 = ap;
  endtask
  task automatic send(input logic [2:0] c, input logic [1:0] b, input logic ap);
    drive(1'b0, c, b, ap);
  endtask
  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(C_NOP, 2'd0, 1'b0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, C_NOP, 2'd0, 1'b0);
  endtask
  // One deselect cycle lets the last command's edge pass, then compare.
  task automatic expect_state(input logic f, input logic [3:0] c, input string tag,
                              input logic uc = 1'b0, input int n = 0);
    exp_t e;
    idle(1);
    e.flag = f; e.code = c; e.use_cnt = uc; e.cnt = n; e.tag = tag;
    sb.push_back(e);
    -> chk_ev;
    #1;
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_state(1'b0, 4'd0, "R1 reset state", 1'b1, 0);

    // R1: deselected patterns ignored; ACT under cs high must not open bank 0
    do_reset();
    drive(1'b1, C_RD, 2'd1, 1'b0);
    drive(1'b1, C_MRS, 2'd0, 1'b0);
    drive(1'b1, C_ACT, 2'd0, 1'b0);
    expect_state(1'b0, 4'd0, "R1 masked commands");
    nops(3);
    send(C_RD, 2'd0, 1'b0);
    expect_state(1'b1, 4'd3, "R1 masked activate left bank closed");

    // R8 legal spacing, R7 reopen, R12 sticky
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(2); send(C_RD, 2'd0, 1'b0);
    expect_state(1'b0, 4'd0, "R8 read at tRCD");
    send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b1, 4'd4, "R7 activate open bank");
    send(C_RD, 2'd2, 1'b0);
    expect_state(1'b1, 4'd4, "R12 first code kept");

    do_reset();
    send(C_RD, 2'd1, 1'b0);
    expect_state(1'b1, 4'd3, "R7 read closed bank");

    do_reset();
    send(C_ACT, 2'd2, 1'b0); nops(1); send(C_RD, 2'd2, 1'b0);
    expect_state(1'b1, 4'd7, "R8 read before tRCD");

    // R9 tRAS and tRP
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(4); send(C_PRE, 2'd0, 1'b0);
    expect_state(1'b1, 4'd8, "R9 precharge before tRAS");
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(5); send(C_PRE, 2'd0, 1'b0);
    nops(1); send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b1, 4'd6, "R9 activate before tRP");

    // R10
    do_reset();
    send(C_ACT, 2'd0, 1'b0); send(C_ACT, 2'd1, 1'b0);
    expect_state(1'b1, 4'd9, "R10 activates too close");

    // R2
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(6); send(C_REF, 2'd0, 1'b0);
    expect_state(1'b1, 4'd1, "R2 refresh with open bank");

    // R3
    do_reset();
    send(C_MRS, 2'd0, 1'b0); nops(1); send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b1, 4'd2, "R3 command second clock after MRS");
    do_reset();
    send(C_MRS, 2'd0, 1'b0); nops(2); send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b0, 4'd0, "R3 command third clock after MRS");

    // R4 busy during auto-precharge burst
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(1); send(C_ACT, 2'd1, 1'b0); nops(3);
    send(C_RD, 2'd0, 1'b1); send(C_RD, 2'd1, 1'b0);
    expect_state(1'b1, 4'd5, "R4 read other bank inside AP burst");

    // R4 bank closed after burst
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(3); send(C_WR, 2'd0, 1'b1);
    nops(3); send(C_RD, 2'd0, 1'b0);
    expect_state(1'b1, 4'd3, "R4 bank closed after AP burst");
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(3); send(C_WR, 2'd0, 1'b1);
    nops(4); send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b1, 4'd6, "R4 activate before tRP after AP end");
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(3); send(C_WR, 2'd0, 1'b1);
    nops(5); send(C_ACT, 2'd0, 1'b0);
    expect_state(1'b0, 4'd0, "R4 activate at tRP after AP end");

    // R6 burst stop
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(3); send(C_RD, 2'd0, 1'b1);
    send(C_BST, 2'd0, 1'b0); send(C_RD, 2'd0, 1'b0);
    expect_state(1'b1, 4'd3, "R6 burst stop ends AP burst");

    // R5 precharge all
    do_reset();
    send(C_ACT, 2'd0, 1'b0); nops(1); send(C_ACT, 2'd1, 1'b0); nops(6);
    send(C_PRE, 2'd3, 1'b1); nops(3); send(C_RD, 2'd1, 1'b0);
    expect_state(1'b1, 4'd3, "R5 precharge all closes bank 1");

    // R11 refresh window
    do_reset();
    send(C_REF, 2'd0, 1'b0); send(C_REF, 2'd0, 1'b0);
    expect_state(1'b0, 4'd0, "R11 refresh counted", 1'b1, 2);
    idle(4100);
    expect_state(1'b0, 4'd0, "R11 window met and cleared", 1'b1, 0);
    idle(3950);
    expect_state(1'b1, 4'd10, "R11 refresh shortfall");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule